// File: doc/BRIEF.md
# Instruction Fetch Branch Target Cache

This block sits between the instruction fetch port of a small 8-bit processor and a slow, read-only flash memory. It keeps 63 fully associative branch entries and one extra linear entry. Each entry holds a 4-byte slot of flash contents, a valid flag and a 15-bit tag. A fetch whose slot is resident returns its byte in the same cycle. A fetch that misses stalls the processor and issues one flash read for the aligned slot. When the flash answers, the block delivers the byte in the next cycle.

Not every miss is kept. The processor supplies a stall threshold, and a miss is written into the cache only when the number of stalled cycles exceeds it. Fetches flagged as landing after a return from interrupt are kept only when a separate enable is set. Fetches flagged as sequential go to the linear entry instead of the branch entries. A branch victim is taken either from a rotating pointer or from a free-running 6-bit LFSR. A flush input empties the whole cache and also cancels a fill that is still waiting for flash.

Top module: `btc_fetch_cache`

## Requirements
- R1: After reset no entry is valid. The first fetch of any address misses: `fetch_stall` and `flash_req` are high in that cycle, and `flash_addr` equals the fetch address with bits 1:0 cleared.
- R2: A fetch whose tag (address bits 16:2) matches a valid entry gets `fetch_stall` low and no flash request in the same cycle. `fetch_data` then equals byte k of the stored 32-bit slot, where k is address bits 1:0 and byte k is bits 8k+7:8k.
- R3: On a miss, `flash_req` is high only in the miss cycle. `fetch_stall` stays high up to and including the cycle in which `flash_valid` is high. In the following cycle `fetch_stall` is low and the requested byte of `flash_rdata` is on `fetch_data`.
- R4: The stall length N is the number of cycles with `fetch_stall` high for one fetch, from the miss cycle through the flash return cycle. The slot is stored only if N is greater than `cfg_thresh`, so a threshold of 0 stores every miss.
- R5: A missed fetch with `fetch_reti` high is stored only while `cfg_reti_en` is 1.
- R6: A missed fetch with `fetch_seq` high is stored in the single linear entry and replaces its previous slot. The branch entries are left untouched.
- R7: With `cfg_rand` at 0, branch fills go to entries 0, 1, …, 62 and then back to 0. The pointer starts at 0 after reset and advances once per branch fill.
- R8: With `cfg_rand` at 1, the victim is the value s of a 6-bit LFSR, with s = 63 mapped to entry 0. The LFSR is 1 during reset and steps on every clock after reset as s' = {s[4:0], s[5]^s[4]}.
- R9: `cfg_flush` high at a clock edge invalidates every branch entry and the linear entry. It also cancels the fill of any miss that is pending in that cycle or was detected earlier and is still waiting. That fetch still completes.
- R10: No two valid branch entries ever hold the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request; held with its address until a cycle with stall low |
| fetch_addr | input | 17 | Flash byte address of the fetch |
| fetch_seq | input | 1 | Fetch is a sequential prefetch (linear entry) |
| fetch_reti | input | 1 | Fetch is the target of a return from interrupt |
| fetch_stall | output | 1 | Processor must wait |
| fetch_data | output | 8 | Fetched byte, valid when request high and stall low |
| flash_req | output | 1 | One-cycle flash read strobe |
| flash_addr | output | 17 | Slot-aligned flash read address |
| flash_valid | input | 1 | Flash read data present, one or more cycles after the strobe |
| flash_rdata | input | 32 | Flash slot contents, byte 0 in bits 7:0 |
| cfg_rand | input | 1 | 1 selects LFSR victim, 0 the rotating pointer |
| cfg_flush | input | 1 | Empty the cache |
| cfg_thresh | input | 2 | Miss stall threshold |
| cfg_reti_en | input | 1 | Allow caching of return-from-interrupt targets |

## Verification
Some properties are checked by assertions on every cycle. The flash strobe lasts one cycle and is followed by a stall. The stall ends in the cycle after flash data arrives. A hit never touches flash. A flush leaves no valid entry in the next cycle. At most one branch entry matches a lookup, and the victim index stays in range. Other behaviour depends on the history of past fetches and only the bench scenarios can show it. This covers the stall-length threshold at both sides of each boundary, the return-from-interrupt filter and the linear entry replacement. It also covers the wrap of the rotating pointer after 63 fills, the exact LFSR victim sequence, and a flush that arrives in the middle of a flash wait.

// File: rtl/btc_pkg.sv
package btc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } btc_state_e;

  localparam int SLOT_BYTES = 4;
  localparam int SLOT_W     = 8 * SLOT_BYTES;

  function automatic logic [7:0] slot_byte(input logic [SLOT_W-1:0] slot,
                                           input logic [1:0] sel);
    return slot[8*sel +: 8];
  endfunction

endpackage

// File: rtl/btc_tag_array.sv
module btc_tag_array #(
  parameter int ENTRIES = 63,
  parameter int TAG_W   = 15,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] valid_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);

  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (wr_en)   valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  assign hit       = |hit_vec;
  assign valid_vec = valid_q;

endmodule

// File: rtl/btc_slot_ram.sv
module btc_slot_ram #(
  parameter int ENTRIES = 63,
  parameter int W       = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] wa,
  input  logic [W-1:0]     wd,
  input  logic [IDX_W-1:0] ra,
  output logic [W-1:0]     rd
);

  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];

endmodule

// File: rtl/btc_victim.sv
module btc_victim #(
  parameter int ENTRIES = 63,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int LFSR_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rand_mode,
  input  logic             advance,
  output logic [IDX_W-1:0] victim
);

  logic [IDX_W-1:0]  ptr_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] folded;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      lfsr_q <= LFSR_W'(1);
    end else begin
      lfsr_q <= {lfsr_q[LFSR_W-2:0], lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_W-2]};
      if (advance)
        ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assign folded = (lfsr_q >= LFSR_W'(ENTRIES)) ? lfsr_q - LFSR_W'(ENTRIES) : lfsr_q;
  assign victim = rand_mode ? IDX_W'(folded) : ptr_q;

endmodule

// File: rtl/btc_fetch_cache.sv
module btc_fetch_cache #(
  parameter int ADDR_W  = 17,
  parameter int ENTRIES = 63,
  parameter int TH_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_seq,
  input  logic              fetch_reti,
  output logic              fetch_stall,
  output logic [7:0]        fetch_data,
  output logic              flash_req,
  output logic [ADDR_W-1:0] flash_addr,
  input  logic              flash_valid,
  input  logic [31:0]       flash_rdata,
  input  logic              cfg_rand,
  input  logic              cfg_flush,
  input  logic [TH_W-1:0]   cfg_thresh,
  input  logic              cfg_reti_en
);
  import btc_pkg::*;

  localparam int TAG_W = ADDR_W - 2;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = TH_W + 1;

  btc_state_e         st_q;
  logic [TAG_W-1:0]   lk_tag, tag_q;
  logic [1:0]         sel_q;
  logic               seq_q, reti_q, cancel_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [SLOT_W-1:0]  hold_q;
  logic               lin_valid_q;
  logic [TAG_W-1:0]   lin_tag_q;
  logic [SLOT_W-1:0]  lin_data_q;

  logic [ENTRIES-1:0] hit_vec, valid_vec;
  logic               br_hit, lin_hit, any_hit;
  logic [IDX_W-1:0]   hit_idx, victim;
  logic [SLOT_W-1:0]  ram_rd;
  logic               miss_now, fill_ok, br_fill, lin_fill, st_wait;

  assign lk_tag   = fetch_addr[ADDR_W-1:2];
  assign lin_hit  = lin_valid_q && (lin_tag_q == lk_tag);
  assign any_hit  = br_hit || lin_hit;
  assign miss_now = (st_q == ST_IDLE) && fetch_req && !any_hit;
  assign st_wait  = (st_q == ST_WAIT);

  // stall length so far is cnt_q + 1 in the return cycle; keep if it exceeds threshold
  assign fill_ok  = st_wait && flash_valid && !cancel_q && !cfg_flush &&
                    (cnt_q >= CNT_W'(cfg_thresh)) && (!reti_q || cfg_reti_en);
  assign br_fill  = fill_ok && !seq_q;
  assign lin_fill = fill_ok && seq_q;

  btc_tag_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst(rst), .flush(cfg_flush), .wr_en(br_fill), .wr_idx(victim),
    .wr_tag(tag_q), .lk_tag(lk_tag), .hit_vec(hit_vec), .valid_vec(valid_vec),
    .hit(br_hit), .hit_idx(hit_idx)
  );

  btc_slot_ram #(.ENTRIES(ENTRIES), .W(SLOT_W), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .we(br_fill), .wa(victim), .wd(flash_rdata), .ra(hit_idx), .rd(ram_rd)
  );

  btc_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .rand_mode(cfg_rand), .advance(br_fill), .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      tag_q    <= '0;
      sel_q    <= '0;
      seq_q    <= 1'b0;
      reti_q   <= 1'b0;
      cancel_q <= 1'b0;
      cnt_q    <= '0;
      hold_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (miss_now) begin
          st_q     <= ST_WAIT;
          tag_q    <= lk_tag;
          sel_q    <= fetch_addr[1:0];
          seq_q    <= fetch_seq;
          reti_q   <= fetch_reti;
          cancel_q <= cfg_flush;
          cnt_q    <= CNT_W'(1);
        end
        ST_WAIT: if (flash_valid) begin
          st_q   <= ST_RESP;
          hold_q <= flash_rdata;
        end else begin
          if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
          if (cfg_flush)   cancel_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_flush) begin
      lin_valid_q <= 1'b0;
    end else if (lin_fill) begin
      lin_valid_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (lin_fill) begin
      lin_tag_q  <= tag_q;
      lin_data_q <= flash_rdata;
    end
  end

  always_comb begin
    fetch_stall = 1'b0;
    fetch_data  = '0;
    unique case (st_q)
      ST_IDLE: begin
        fetch_stall = miss_now;
        if (br_hit)       fetch_data = slot_byte(ram_rd, fetch_addr[1:0]);
        else if (lin_hit) fetch_data = slot_byte(lin_data_q, fetch_addr[1:0]);
      end
      ST_WAIT: fetch_stall = 1'b1;
      default: fetch_data  = slot_byte(hold_q, sel_q);
    endcase
  end

  assign flash_req  = miss_now;
  assign flash_addr = {lk_tag, 2'b00};

endmodule

// File: rtl/btc_fetch_cache_chk.sv
module btc_fetch_cache_chk #(
  parameter int ENTRIES = 63,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst,
  input logic               fetch_req,
  input logic               fetch_stall,
  input logic               flash_req,
  input logic               flash_valid,
  input logic               cfg_flush,
  input logic               st_wait,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic               lin_valid,
  input logic [IDX_W-1:0]   victim
);

  // R3
  flash_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    flash_req |=> !flash_req);

  // R3
  miss_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    flash_req |=> fetch_stall);

  // R3
  release_after_data_chk: assert property (@(posedge clk) disable iff (rst)
    (st_wait && flash_valid) |=> !fetch_stall);

  // R2
  hit_no_flash_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !fetch_stall) |-> !flash_req);

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_flush |=> ((valid_vec == '0) && !lin_valid));

  // R10
  unique_tag_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R7
  victim_range_chk: assert property (@(posedge clk) disable iff (rst)
    victim < IDX_W'(ENTRIES));

endmodule

bind btc_fetch_cache btc_fetch_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_stall(fetch_stall),
  .flash_req(flash_req), .flash_valid(flash_valid), .cfg_flush(cfg_flush),
  .st_wait(st_wait), .hit_vec(hit_vec), .valid_vec(valid_vec),
  .lin_valid(lin_valid_q), .victim(victim)
);

// File: tb/btc_fetch_cache_test.sv
module btc_fetch_cache_test;
  localparam int AW = 17;
  localparam int NE = 63;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fetch_req = 1'b0, fetch_seq = 1'b0, fetch_reti = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_stall, flash_req;
  logic [7:0]    fetch_data;
  logic [AW-1:0] flash_addr;
  logic          flash_valid = 1'b0;
  logic [31:0]   flash_rdata = '0;
  logic          cfg_rand = 1'b0, cfg_flush = 1'b0, cfg_reti_en = 1'b0;
  logic [1:0]    cfg_thresh = 2'd0;

  btc_fetch_cache uut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_seq(fetch_seq), .fetch_reti(fetch_reti), .fetch_stall(fetch_stall),
    .fetch_data(fetch_data), .flash_req(flash_req), .flash_addr(flash_addr),
    .flash_valid(flash_valid), .flash_rdata(flash_rdata), .cfg_rand(cfg_rand),
    .cfg_flush(cfg_flush), .cfg_thresh(cfg_thresh), .cfg_reti_en(cfg_reti_en)
  );

  always #2 clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    g_done;

  // flash responder
  int lat = 1, fl_left = 0;
  bit fl_act = 0;
  int fl_addr = 0;

  // behavioural model
  int m_tag[NE];
  int m_lin, m_ptr, m_lfsr, m_st, m_cnt, m_addr;
  bit m_cancel, m_seq, m_reti;

  function automatic logic [31:0] fword(int a);
    logic [31:0] al;
    al = 32'(a & ~3);
    return (al * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [7:0] fbyte(int a);
    return 8'(fword(a) >> (8 * (a & 3)));
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic step();
    bit hit;
    int tag, v;
    bit e_stall, e_freq;
    if (fl_act && fl_left > 0) fl_left--;
    flash_valid = fl_act && (fl_left == 0);
    flash_rdata = flash_valid ? fword(fl_addr) : 32'h0;
    #1;
    tag = int'(fetch_addr) >> 2;
    hit = 0;
    if (m_st == 0 && fetch_req) begin
      foreach (m_tag[i]) if (m_tag[i] == tag) hit = 1;
      if (m_lin == tag) hit = 1;
    end
    e_freq  = (m_st == 0) && fetch_req && !hit;
    e_stall = (m_st == 1) || e_freq;
    chk(fetch_stall === e_stall, "fetch_stall", int'(fetch_stall), int'(e_stall));
    chk(flash_req === e_freq, "flash_req", int'(flash_req), int'(e_freq));
    if (e_freq)
      chk(flash_addr === AW'(tag << 2), "flash_addr", int'(flash_addr), tag << 2);
    g_done = fetch_req && !e_stall;
    if (g_done)
      chk(fetch_data === fbyte(int'(fetch_addr)), "fetch_data",
          int'(fetch_data), int'(fbyte(int'(fetch_addr))));
    if (flash_valid) fl_act = 0;
    if (e_freq) begin fl_act = 1; fl_left = lat; fl_addr = int'(fetch_addr); end
    case (m_st)
      0: if (e_freq) begin
        m_st = 1; m_addr = int'(fetch_addr); m_seq = fetch_seq; m_reti = fetch_reti;
        m_cnt = 1; m_cancel = cfg_flush;
      end
      1: if (flash_valid) begin
        if (!m_cancel && !cfg_flush && (m_cnt + 1 > int'(cfg_thresh)) &&
            (!m_reti || cfg_reti_en)) begin
          if (m_seq) m_lin = m_addr >> 2;
          else begin
            v = cfg_rand ? ((m_lfsr >= NE) ? m_lfsr - NE : m_lfsr) : m_ptr;
            m_tag[v] = m_addr >> 2;
            m_ptr = (m_ptr + 1) % NE;
          end
        end
        m_st = 2;
      end else begin
        m_cnt++;
        if (cfg_flush) m_cancel = 1;
      end
      default: m_st = 0;
    endcase
    if (cfg_flush) begin
      foreach (m_tag[i]) m_tag[i] = -1;
      m_lin = -1;
    end
    m_lfsr = ((m_lfsr << 1) & 63) | (((m_lfsr >> 5) ^ (m_lfsr >> 4)) & 1);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    fetch_req = 0;
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic flush_now();
    fetch_req = 0; cfg_flush = 1; step(); cfg_flush = 0;
  endtask

  task automatic do_fetch(int a, bit s = 0, bit r = 0, int l = 1, int flush_at = -1);
    int k = 0;
    lat = l; fetch_req = 1; fetch_addr = AW'(a); fetch_seq = s; fetch_reti = r;
    do begin
      cfg_flush = (k == flush_at);
      step();
      k++;
    end while (!g_done);
    cfg_flush = 0; fetch_req = 0; fetch_seq = 0; fetch_reti = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    foreach (m_tag[i]) m_tag[i] = -1;
    m_lin = -1; m_ptr = 0; m_lfsr = 1; m_st = 0; m_cnt = 0; m_addr = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state, idle outputs and first-fetch miss
    cur_req = "R1";
    idle(2);
    do_fetch(17'h00105, 0, 0, 1);

    // R2: every byte of a resident slot hits
    cur_req = "R2";
    for (int b = 0; b < 4; b++) do_fetch(17'h00104 + b);

    // R3: varied flash latencies
    cur_req = "R3";
    for (int l = 1; l <= 6; l++) begin
      do_fetch(17'h02000 + l * 8 + (l & 3), 0, 0, l);
      do_fetch(17'h02000 + l * 8);
    end

    // R4: threshold boundaries (N = latency + 1)
    cur_req = "R4";
    cfg_thresh = 2;
    do_fetch(17'h03000, 0, 0, 1);   // N=2 not kept
    do_fetch(17'h03001, 0, 0, 2);   // misses again, N=3 kept
    do_fetch(17'h03002);            // hit
    cfg_thresh = 3;
    do_fetch(17'h03100, 0, 0, 2);   // N=3 not kept
    do_fetch(17'h03100, 0, 0, 3);   // N=4 kept
    do_fetch(17'h03103);
    cfg_thresh = 0;

    // R5: return-from-interrupt filter
    cur_req = "R5";
    do_fetch(17'h04000, 0, 1, 1);
    do_fetch(17'h04001, 0, 1, 1);   // still a miss
    cfg_reti_en = 1;
    do_fetch(17'h04002, 0, 1, 1);
    do_fetch(17'h04003, 0, 1, 1);   // hit now
    cfg_reti_en = 0;

    // R6: linear entry holds one sequential slot
    cur_req = "R6";
    do_fetch(17'h05000, 1, 0, 1);
    do_fetch(17'h05002, 1);
    do_fetch(17'h05010, 1, 0, 2);
    do_fetch(17'h05001, 1, 0, 1);   // replaced: misses
    do_fetch(17'h00106);            // branch entry untouched

    // R9: flush idle and flush during a pending fill
    cur_req = "R9";
    flush_now();
    do_fetch(17'h00104);            // misses after flush
    do_fetch(17'h06000, 0, 0, 4, 2);
    do_fetch(17'h06001, 0, 0, 1);   // was cancelled: misses
    do_fetch(17'h06100, 0, 0, 1, 0);
    do_fetch(17'h06100, 0, 0, 1);
    do_fetch(17'h06102);

    // R7: rotating replacement wraps after 63 fills
    cur_req = "R7";
    flush_now();
    for (int t = 0; t < 70; t++) do_fetch(17'h08000 + t * 4 + (t & 3));
    for (int t = 0; t < 70; t++) do_fetch(17'h08000 + t * 4 + ((t + 1) & 3));

    // R8: LFSR replacement
    cur_req = "R8";
    cfg_rand = 1;
    flush_now();
    for (int t = 0; t < 90; t++) begin
      do_fetch(17'h0C000 + t * 28 + (t & 3), 0, 0, 1 + (t % 3));
      if (t % 5 == 0) idle(t % 4);
    end

    // R10: refetch after random fills; each lookup matches at most one entry
    cur_req = "R10";
    for (int t = 0; t < 90; t++) do_fetch(17'h0C000 + t * 28 + 2);
    cfg_rand = 0;
    idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule